// File: doc/BRIEF.md
# Power Reset Supervisor with Activity Watchdog

This block produces one reset state and presents it as two complementary open-drain reset enables, plus a memory-inhibit signal for a neighbouring EEPROM controller. Reset comes from four sources. The first is a digital supply-good flag from an external comparator, which passes through a glitch filter. The other three are a rising edge seen on the active-high reset pin, a falling edge seen on the active-low reset pin, and a watchdog that expires when the serial data line stays idle. Each source loads a single timeout counter. The reset outputs release when that counter runs out, even if the source that caused the reset is still present.

Every interval is a parameter counted in system clock ticks, so a simulation can use short values and silicon can use the full durations. The reset pins are read back through synchronizers. A readback edge is accepted as a manual request only while the block is not driving either pin, and only after the readback has had time to settle, so the block never triggers on its own drive. A parameter removes the watchdog for the variant that lacks it.

Top module: `pwr_rst_supervisor`

## Requirements
- R1: During and right after synchronous reset, both reset enables and the memory inhibit are high. The block assumes the supply is bad until the supply flag reports good.
- R2: After the supply flag goes and stays high, both enables stay high for HOLD_TICKS cycles (plus a few cycles of synchronizer latency) and then both go low together. The memory inhibit goes low with them.
- R3: If the supply flag is low for at least GLITCH_TICKS consecutive cycles, both enables and the memory inhibit go high.
- R4: A supply-low pulse shorter than GLITCH_TICKS cycles causes no reset.
- R5: A rising edge on the active-high pin readback starts a reset of HOLD_TICKS cycles, and the outputs then release.
- R6: A falling edge on the active-low pin readback starts a reset of HOLD_TICKS cycles, and the outputs then release.
- R7: A manual input held active longer than the timeout does not stretch the reset: the enables release after HOLD_TICKS. The memory inhibit stays high for as long as the pin is held active, where active means high on the active-high pin or low on the active-low pin.
- R8: With the watchdog present, WDOG_TICKS cycles without any transition on the data line cause a reset of HOLD_TICKS cycles.
- R9: Any transition on the data line, rising or falling, restarts the watchdog count. A line that toggles more often than once every WDOG_TICKS cycles never causes a reset.
- R10: The watchdog does not count while reset is active. After a release, a full WDOG_TICKS idle period is needed before the next expiry.
- R11: The active-high enable and the active-low enable are always equal. The memory inhibit is high whenever they are.
- R12: With HAS_WDOG = 0, an idle data line never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, asynchronous |
| rst_hi_pin_i | input | 1 | Level read back from the active-high reset pin, asynchronous |
| rst_lo_n_pin_i | input | 1 | Level read back from the active-low reset pin, asynchronous |
| sda_i | input | 1 | Serial data line, monitored for activity |
| rst_hi_oe_o | output | 1 | Drive enable that pulls the active-high pin high |
| rst_lo_oe_o | output | 1 | Drive enable that pulls the active-low pin low |
| mem_inhibit_o | output | 1 | Blocks memory access while reset is active or a manual reset is held |

## Verification
A wrong internal state shows up at the enables within a few cycles. If the timeout counter is loaded wrongly, the release edge moves away from HOLD_TICKS after the last trigger. If the glitch counter is off, a short dip asserts reset or a long dip fails to. If the watchdog keeps counting during reset, it expires early; this is visible as a second reset less than WDOG_TICKS cycles after a release. A fault in edge detection shows up as a missed manual reset, or as a reset that re-triggers while a pin is held. A fault in the inhibit path shows up as the inhibit dropping while a pin is still held active.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    // Levels the two reset pins settle to when nothing drives them.
    localparam logic PIN_HI_IDLE   = 1'b0;
    localparam logic PIN_LO_N_IDLE = 1'b1;
    localparam logic SDA_IDLE      = 1'b1;

    // Synchronized view of both reset pins.
    typedef struct packed {
        logic hi;
        logic lo_n;
    } pin_pair_t;

    // Reasons that can start a reset timeout.
    typedef struct packed {
        logic manual;
        logic watchdog;
    } trig_src_t;

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // True when either pin shows its asserted level.
    function automatic logic pin_asserted(input pin_pair_t p);
        return p.hi || !p.lo_n;
    endfunction

endpackage

// File: rtl/psv_sync.sv
module psv_sync #(
    parameter int          STAGES = 2,
    parameter int          W      = 1,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= INIT;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= INIT;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/psv_supply_filter.sv
module psv_supply_filter #(
    parameter int GLITCH_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ok_s,
    output logic bad_q
);
    import pwr_sup_pkg::*;
    localparam int GW = cnt_width(GLITCH_TICKS);

    logic [GW-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q     <= 1'b1;
            low_run_q <= '0;
        end else if (ok_s) begin
            bad_q     <= 1'b0;
            low_run_q <= '0;
        end else if (!bad_q) begin
            if (low_run_q == GW'(GLITCH_TICKS - 1)) begin
                bad_q     <= 1'b1;
                low_run_q <= '0;
            end else begin
                low_run_q <= low_run_q + 1'b1;
            end
        end
    end

    // R3: a new supply fault is only declared after the flag was seen low
    p_fault_needs_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bad_q) |-> !$past(ok_s));

    // R4: a good sample always clears the fault on the next edge
    p_good_clears_r4: assert property (@(posedge clk) disable iff (rst)
        ok_s |=> !bad_q);
endmodule

// File: rtl/psv_manual_sense.sv
module psv_manual_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pwr_sup_pkg::pin_pair_t pins_s,
    input  logic                  active,
    output logic                  trig,
    output logic                  held
);
    import pwr_sup_pkg::*;
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int QW     = cnt_width(SETTLE);

    pin_pair_t      pins_d;
    logic [QW-1:0]  quiet_q;
    logic           armed;
    logic           hi_rise;
    logic           lo_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_d.hi   <= PIN_HI_IDLE;
            pins_d.lo_n <= PIN_LO_N_IDLE;
            quiet_q     <= '0;
        end else begin
            pins_d <= pins_s;
            if (active)
                quiet_q <= '0;
            else if (quiet_q != QW'(SETTLE))
                quiet_q <= quiet_q + 1'b1;
        end
    end

    // Our own drive must have been off long enough to leave the synchronizers.
    assign armed   = !active && (quiet_q == QW'(SETTLE));
    assign hi_rise = pins_s.hi && !pins_d.hi;
    assign lo_fall = !pins_s.lo_n && pins_d.lo_n;
    assign trig    = armed && (hi_rise || lo_fall);
    assign held    = pin_asserted(pins_s);

    // R5/R6: an accepted manual edge always puts the block into reset
    p_manual_starts_r5: assert property (@(posedge clk) disable iff (rst)
        trig |=> active);
endmodule

// File: rtl/psv_watchdog.sv
module psv_watchdog #(
    parameter int WDOG_TICKS  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_i,
    input  logic active,
    output logic fire_q
);
    import pwr_sup_pkg::*;
    localparam int WW = cnt_width(WDOG_TICKS);

    logic          sda_s;
    logic          sda_d;
    logic [WW-1:0] idle_q;

    psv_sync #(.STAGES(SYNC_STAGES), .W(1), .INIT(SDA_IDLE)) u_sda_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_d  <= SDA_IDLE;
            idle_q <= '0;
            fire_q <= 1'b0;
        end else begin
            sda_d  <= sda_s;
            fire_q <= 1'b0;
            if (active || (sda_s != sda_d)) begin
                idle_q <= '0;
            end else if (idle_q == WW'(WDOG_TICKS - 1)) begin
                idle_q <= '0;
                fire_q <= 1'b1;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R10: the idle count stays cleared while reset is active
    p_held_clear_r10: assert property (@(posedge clk) disable iff (rst)
        active |=> (idle_q == '0));

    // R8: an expiry is a single-cycle event
    p_single_fire_r8: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    // R9: a line transition never coincides with an expiry on the next edge
    p_edge_blocks_fire_r9: assert property (@(posedge clk) disable iff (rst)
        (sda_s != sda_d) |=> !fire_q);
endmodule

// File: rtl/psv_timeout.sv
module psv_timeout #(
    parameter int HOLD_TICKS = 40
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   supply_bad,
    input  pwr_sup_pkg::trig_src_t trig,
    output logic                   active
);
    import pwr_sup_pkg::*;
    localparam int HW = cnt_width(HOLD_TICKS);

    logic [HW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= HW'(HOLD_TICKS);
        else if (supply_bad || trig.manual || trig.watchdog)
            remain_q <= HW'(HOLD_TICKS);
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign active = supply_bad || (remain_q != '0);

    // R3: a supply fault reloads the full timeout
    p_fault_reloads_r3: assert property (@(posedge clk) disable iff (rst)
        supply_bad |=> (remain_q == HW'(HOLD_TICKS)));

    // R2: reset ends only when the count has just run out with the supply good
    p_release_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(remain_q) == HW'(1)) && !$past(supply_bad));
endmodule

// File: rtl/pwr_rst_supervisor.sv
module pwr_rst_supervisor #(
    parameter int GLITCH_TICKS = 8,
    parameter int HOLD_TICKS   = 40,
    parameter int WDOG_TICKS   = 100,
    parameter int SYNC_STAGES  = 2,
    parameter bit HAS_WDOG     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic rst_hi_pin_i,
    input  logic rst_lo_n_pin_i,
    input  logic sda_i,
    output logic rst_hi_oe_o,
    output logic rst_lo_oe_o,
    output logic mem_inhibit_o
);
    import pwr_sup_pkg::*;

    logic      supply_s;
    logic      supply_bad;
    pin_pair_t pins_raw;
    pin_pair_t pins_s;
    trig_src_t trig;
    logic      active;
    logic      manual_held;

    psv_sync #(.STAGES(SYNC_STAGES), .W(1), .INIT(1'b0)) u_supply_sync (
        .clk (clk),
        .rst (rst),
        .d   (supply_ok_i),
        .q   (supply_s)
    );

    psv_supply_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .ok_s  (supply_s),
        .bad_q (supply_bad)
    );

    assign pins_raw.hi   = rst_hi_pin_i;
    assign pins_raw.lo_n = rst_lo_n_pin_i;

    psv_sync #(.STAGES(SYNC_STAGES), .W(2), .INIT({PIN_HI_IDLE, PIN_LO_N_IDLE})) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    psv_manual_sense #(.SYNC_STAGES(SYNC_STAGES)) u_manual (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .active (active),
        .trig   (trig.manual),
        .held   (manual_held)
    );

    if (HAS_WDOG) begin : g_wdog
        psv_watchdog #(.WDOG_TICKS(WDOG_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_wdog (
            .clk    (clk),
            .rst    (rst),
            .sda_i  (sda_i),
            .active (active),
            .fire_q (trig.watchdog)
        );
    end else begin : g_no_wdog
        assign trig.watchdog = 1'b0;
        logic unused_sda;
        assign unused_sda = sda_i;
    end

    psv_timeout #(.HOLD_TICKS(HOLD_TICKS)) u_timeout (
        .clk        (clk),
        .rst        (rst),
        .supply_bad (supply_bad),
        .trig       (trig),
        .active     (active)
    );

    assign rst_hi_oe_o   = active;
    assign rst_lo_oe_o   = active;
    assign mem_inhibit_o = active || manual_held;

    // R2: when the filtered supply turns good, reset continues for the timeout
    p_hold_after_good_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_bad) |-> rst_hi_oe_o && rst_lo_oe_o);

    // R7: a held pin keeps the memory inhibited after the enables release
    p_held_inhibits_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst_hi_oe_o) && manual_held) |-> mem_inhibit_o);

    // R11: both enables are the same on every cycle
    p_enables_agree_r11: assert property (@(posedge clk) disable iff (rst)
        rst_hi_oe_o == rst_lo_oe_o);
endmodule

// File: tb/pwr_rst_supervisor_bench.sv
`timescale 1ns/1ps
module pwr_rst_supervisor_bench;
    localparam int GT = 8;
    localparam int HT = 40;
    localparam int WT = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic ext_hi = 1'b0;
    logic ext_lo = 1'b0;
    logic sda = 1'b1;
    bit   sda_auto = 1'b0;

    logic hi_oe1, lo_oe1, inh1;
    logic hi_oe2, lo_oe2, inh2;
    logic hi_pin1, lo_n_pin1, hi_pin2, lo_n_pin2;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain pins with pull resistors, plus an external push-button force.
    assign hi_pin1   = hi_oe1 | ext_hi;
    assign lo_n_pin1 = !(lo_oe1 | ext_lo);
    assign hi_pin2   = hi_oe2 | ext_hi;
    assign lo_n_pin2 = !(lo_oe2 | ext_lo);

    pwr_rst_supervisor #(.GLITCH_TICKS(GT), .HOLD_TICKS(HT), .WDOG_TICKS(WT),
                         .SYNC_STAGES(2), .HAS_WDOG(1'b1)) u_pwr_rst_supervisor (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok),
        .rst_hi_pin_i(hi_pin1), .rst_lo_n_pin_i(lo_n_pin1), .sda_i(sda),
        .rst_hi_oe_o(hi_oe1), .rst_lo_oe_o(lo_oe1), .mem_inhibit_o(inh1));

    pwr_rst_supervisor #(.GLITCH_TICKS(GT), .HOLD_TICKS(HT), .WDOG_TICKS(WT),
                         .SYNC_STAGES(2), .HAS_WDOG(1'b0)) u_pwr_rst_supervisor_nowd (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok),
        .rst_hi_pin_i(hi_pin2), .rst_lo_n_pin_i(lo_n_pin2), .sda_i(1'b1),
        .rst_hi_oe_o(hi_oe2), .rst_lo_oe_o(lo_oe2), .mem_inhibit_o(inh2));

    typedef struct {
        int    when;
        bit    dut2;
        logic  drv;
        int    inh;   // 0, 1, or 2 for "not checked"
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // Driver side: queue an expectation `d` cycles from now, kept in time order.
    task automatic expect_at(input int d, input bit dut2, input logic drv,
                             input int inh, input string tag);
        exp_t it;
        int   pos;
        it.when = cyc + d; it.dut2 = dut2; it.drv = drv; it.inh = inh; it.tag = tag;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].when > it.when) begin pos = i; break; end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_release(output int r);
        @(negedge clk);
        while (hi_oe1) @(negedge clk);
        r = cyc;
    endtask

    // Monitor: compare queued items at the falling edge of their cycle.
    always @(negedge clk) begin
        while (sb_q.size() != 0 && sb_q[0].when <= cyc) begin
            exp_t it;
            logic a_hi, a_lo, a_inh;
            it = sb_q.pop_front();
            a_hi  = it.dut2 ? hi_oe2 : hi_oe1;
            a_lo  = it.dut2 ? lo_oe2 : lo_oe1;
            a_inh = it.dut2 ? inh2   : inh1;
            n_checks++;
            if (a_hi !== it.drv) begin
                n_fail++;
                $display("FAIL %s cyc=%0d hi_oe actual=%b expected=%b", it.tag, cyc, a_hi, it.drv);
            end else if (a_lo !== it.drv) begin
                n_fail++;
                $display("FAIL %s/R11 cyc=%0d lo_oe actual=%b expected=%b", it.tag, cyc, a_lo, it.drv);
            end else if (it.inh != 2 && a_inh !== it.inh[0]) begin
                n_fail++;
                $display("FAIL %s cyc=%0d inhibit actual=%b expected=%0d", it.tag, cyc, a_inh, it.inh);
            end
        end
    end

    // Background activity on the data line, toggling well inside the watchdog period.
    initial begin
        forever begin
            repeat (20) @(negedge clk);
            if (sda_auto) sda = ~sda;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, supply still reported bad
        expect_at(0, 0, 1'b1, 1, "R1");
        expect_at(0, 1, 1'b1, 1, "R1");
        expect_at(5, 0, 1'b1, 1, "R1");
        drain();

        // R2: supply comes good, reset holds for the timeout, then releases
        supply_ok = 1'b1;
        sda_auto  = 1'b1;
        expect_at(HT, 0, 1'b1, 1, "R2");
        expect_at(HT + 6, 0, 1'b0, 0, "R2");
        expect_at(HT + 6, 1, 1'b0, 0, "R2");
        drain();

        // R4: short supply dip is filtered out
        supply_ok = 1'b0;
        expect_at(2, 0, 1'b0, 0, "R4");
        expect_at(6, 0, 1'b0, 0, "R4");
        expect_at(GT + 6, 0, 1'b0, 0, "R4");
        expect_at(GT + 12, 0, 1'b0, 0, "R4");
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        drain();

        // R3: long supply dip asserts reset
        supply_ok = 1'b0;
        expect_at(GT - 2, 0, 1'b0, 0, "R3");
        expect_at(GT + 6, 0, 1'b1, 1, "R3");
        expect_at(GT + 6, 1, 1'b1, 1, "R3");
        repeat (20) @(negedge clk);
        supply_ok = 1'b1;
        drain();
        wait_release(r);
        repeat (10) @(negedge clk);

        // R5: rising edge on the active-high pin
        ext_hi = 1'b1;
        expect_at(6, 0, 1'b1, 1, "R5");
        expect_at(HT, 0, 1'b1, 1, "R5");
        expect_at(HT + 6, 0, 1'b0, 0, "R5");
        repeat (2) @(negedge clk);
        ext_hi = 1'b0;
        drain();
        repeat (10) @(negedge clk);

        // R6: falling edge on the active-low pin
        ext_lo = 1'b1;
        expect_at(6, 0, 1'b1, 1, "R6");
        expect_at(HT, 0, 1'b1, 1, "R6");
        expect_at(HT + 6, 0, 1'b0, 0, "R6");
        repeat (2) @(negedge clk);
        ext_lo = 1'b0;
        drain();
        repeat (10) @(negedge clk);

        // R7: held manual input does not stretch reset but keeps memory inhibited
        ext_hi = 1'b1;
        expect_at(6, 0, 1'b1, 1, "R7");
        expect_at(HT + 6, 0, 1'b0, 1, "R7");
        expect_at(HT + 30, 0, 1'b0, 1, "R7");
        repeat (90) @(negedge clk);
        ext_hi = 1'b0;
        expect_at(6, 0, 1'b0, 0, "R7");
        drain();
        repeat (10) @(negedge clk);
        ext_lo = 1'b1;
        expect_at(HT + 30, 0, 1'b0, 1, "R7");
        repeat (90) @(negedge clk);
        ext_lo = 1'b0;
        expect_at(6, 0, 1'b0, 0, "R7");
        drain();

        // R8/R10/R12: data line goes idle
        sda_auto = 1'b0;
        repeat (5) @(negedge clk);
        ext_hi = 1'b1;
        repeat (2) @(negedge clk);
        ext_hi = 1'b0;
        wait_release(r);
        expect_at(WT - 3, 0, 1'b0, 0, "R10");
        expect_at(WT + 4, 0, 1'b1, 1, "R8");
        expect_at(WT + 4, 1, 1'b0, 0, "R12");
        drain();
        wait_release(r);
        expect_at(WT - 3, 0, 1'b0, 0, "R10");
        expect_at(WT + 4, 0, 1'b1, 1, "R8");
        expect_at(2 * WT + 10, 1, 1'b0, 0, "R12");
        drain();
        wait_release(r);

        // R9: regular activity on the data line keeps the watchdog quiet
        sda_auto = 1'b1;
        for (int k = 1; k <= 12; k++) expect_at(25 * k, 0, 1'b0, 0, "R9");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule